// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block turns events on a group of external processor control pins into the request and control levels that a core consumes. Pin activity arrives as one event per cycle: a valid strobe, a 3-bit pin index and the new logical level of that pin, where 1 means asserted. The block keeps one stored bit per pin that holds the last level it accepted. An event whose level equals the stored bit is dropped, so repeated reports of an unchanged pin cause no action.

Each accepted change is handled by the rule of its own pin. The external and thermal interrupt requests follow their pins. The soft-reset request follows its pin. The checkstop pin holds the halt flag. A falling edge on the machine-check pin sets a sticky request, which the core clears with a one-cycle acknowledge. A rising edge on the hard-reset pin gives a one-cycle pulse. The time-base enable pin is only stored. The block does not prioritise interrupts and does not take them. All outputs are registered and change one clock edge after the event is sampled.

Top module: `irq_pin_conditioner`

## Requirements
- R1: While rst_ni is low, every request output, halt_o, hrst_o and all bits of pin_state_o are 0.
- R2: An event whose level equals the stored bit of its pin is ignored: no output and no stored bit changes. A cycle with pin_vld_i low has no pin effect.
- R3: An accepted change sets or clears bit pin_idx_i of pin_state_o to the new level on the next edge.
- R4: Index 0 (external interrupt) is level-sensitive and active high. ext_irq_o takes the accepted level one cycle after the event.
- R5: Index 1 (thermal) is level-sensitive and active high. therm_irq_o takes the accepted level one cycle after the event.
- R6: Index 2 (machine check) reacts to a falling edge only. An accepted 1-to-0 change sets mck_req_o on the next cycle. A 0-to-1 change leaves mck_req_o as it was.
- R7: mck_req_o stays set until a cycle with mck_ack_i high clears it on the following edge. If a machine-check set and an acknowledge occur in the same cycle, the set wins.
- R8: Index 3 (checkstop) drives halt_o: an accepted 1 halts the core and an accepted 0 restarts it, one cycle after the event.
- R9: Index 4 (hard reset) produces hrst_o high for exactly one cycle after an accepted 0-to-1 change. A 1-to-0 change gives no pulse.
- R10: Index 5 (soft reset) drives srst_req_o to the accepted level one cycle after the event.
- R11: Index 6 (time-base enable) changes only its bit of pin_state_o and no other output.
- R12: Index 7 is outside the pin set. Such an event changes neither pin_state_o nor any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_vld_i | input | 1 | Pin event valid this cycle |
| pin_idx_i | input | 3 | Index of the pin that reports an event |
| pin_lvl_i | input | 1 | New logical level of that pin (1 = asserted) |
| mck_ack_i | input | 1 | Core acknowledge; clears the machine-check request |
| ext_irq_o | output | 1 | External interrupt request |
| therm_irq_o | output | 1 | Thermal interrupt request |
| mck_req_o | output | 1 | Sticky machine-check request |
| srst_req_o | output | 1 | Soft-reset interrupt request |
| halt_o | output | 1 | Core halt flag from checkstop |
| hrst_o | output | 1 | One-cycle hard-reset pulse |
| pin_state_o | output | 7 | Stored last accepted level of each pin |

## Verification
A machine-check falling edge and a core acknowledge can arrive in the same cycle, and the block must then keep the request set. The bench first raises the machine-check pin. It then drops the pin while it pulses mck_ack_i in the same cycle, and the scoreboard expects mck_req_o to be 1 on the next edge. A second case sends a repeated low level together with an acknowledge. The scoreboard expects the request to clear, since the repeat is not an edge.

// File: rtl/pin_cond_pkg.sv
package pin_cond_pkg;
  localparam int unsigned NUM_PINS = 7;
  localparam int unsigned IDX_W    = 3;

  typedef enum logic [IDX_W-1:0] {
    PIN_EXT    = 3'd0,
    PIN_THERM  = 3'd1,
    PIN_MCK    = 3'd2,
    PIN_CKSTOP = 3'd3,
    PIN_HRST   = 3'd4,
    PIN_SRST   = 3'd5,
    PIN_TBEN   = 3'd6
  } pin_id_e;

  typedef struct packed {
    logic ext_irq;
    logic therm_irq;
    logic mck_req;
    logic srst_req;
    logic halt;
    logic hrst_pulse;
  } req_t;
endpackage

// File: rtl/pin_cond_filter.sv
module pin_cond_filter #(
  parameter int unsigned NUM_PINS = 7,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vld_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                lvl_i,
  output logic [NUM_PINS-1:0] chg_o,
  output logic [NUM_PINS-1:0] state_o
);
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] state_q;

  // An index with no matching pin hits nothing, so it is dropped.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign hit[p]   = vld_i && (idx_i == IDX_W'(p));
    assign chg_o[p] = hit[p] && (state_q[p] != lvl_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       state_q[p] <= 1'b0;
      else if (chg_o[p]) state_q[p] <= lvl_i;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/pin_cond_action.sv
module pin_cond_action
  import pin_cond_pkg::*;
#(
  parameter int unsigned NUM_PINS = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] chg_i,
  input  logic                lvl_i,
  input  logic                ack_i,
  output req_t                req_o
);
  req_t req_q, req_d;
  logic mck_fall;

  assign mck_fall = chg_i[PIN_MCK] && !lvl_i;

  always_comb begin
    req_d            = req_q;
    req_d.hrst_pulse = chg_i[PIN_HRST] && lvl_i;
    if (chg_i[PIN_EXT])    req_d.ext_irq   = lvl_i;
    if (chg_i[PIN_THERM])  req_d.therm_irq = lvl_i;
    if (chg_i[PIN_SRST])   req_d.srst_req  = lvl_i;
    if (chg_i[PIN_CKSTOP]) req_d.halt      = lvl_i;
    // new edge beats a same-cycle acknowledge
    if (mck_fall)          req_d.mck_req   = 1'b1;
    else if (ack_i)        req_d.mck_req   = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/irq_pin_conditioner.sv
module irq_pin_conditioner
  import pin_cond_pkg::*;
#(
  parameter int unsigned NUM_PINS = pin_cond_pkg::NUM_PINS,
  parameter int unsigned IDX_W    = pin_cond_pkg::IDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pin_vld_i,
  input  logic [IDX_W-1:0]    pin_idx_i,
  input  logic                pin_lvl_i,
  input  logic                mck_ack_i,
  output logic                ext_irq_o,
  output logic                therm_irq_o,
  output logic                mck_req_o,
  output logic                srst_req_o,
  output logic                halt_o,
  output logic                hrst_o,
  output logic [NUM_PINS-1:0] pin_state_o
);
  logic [NUM_PINS-1:0] chg;
  req_t                req;

  pin_cond_filter #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (pin_vld_i),
    .idx_i   (pin_idx_i),
    .lvl_i   (pin_lvl_i),
    .chg_o   (chg),
    .state_o (pin_state_o)
  );

  pin_cond_action #(.NUM_PINS(NUM_PINS)) u_action (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .chg_i  (chg),
    .lvl_i  (pin_lvl_i),
    .ack_i  (mck_ack_i),
    .req_o  (req)
  );

  assign ext_irq_o   = req.ext_irq;
  assign therm_irq_o = req.therm_irq;
  assign mck_req_o   = req.mck_req;
  assign srst_req_o  = req.srst_req;
  assign halt_o      = req.halt;
  assign hrst_o      = req.hrst_pulse;
endmodule

// File: rtl/irq_pin_conditioner_chk.sv
module irq_pin_conditioner_chk #(
  parameter int unsigned NUM_PINS = 7,
  parameter int unsigned IDX_W    = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                pin_vld_i,
  input logic [IDX_W-1:0]    pin_idx_i,
  input logic                pin_lvl_i,
  input logic                mck_ack_i,
  input logic                ext_irq_o,
  input logic                mck_req_o,
  input logic                halt_o,
  input logic                hrst_o,
  input logic [NUM_PINS-1:0] pin_state_o
);
  logic [7:0] st_ext;
  logic       cur_bit;
  logic       mck_set_ev;

  assign st_ext     = 8'(pin_state_o);
  assign cur_bit    = st_ext[pin_idx_i];
  assign mck_set_ev = pin_vld_i && pin_idx_i == 3'd2 && !pin_lvl_i && cur_bit;

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_state_chk: assert (pin_state_o == '0 && !hrst_o && !mck_req_o && !halt_o);
    end
  end

  // R2
  repeat_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_vld_i && pin_idx_i < 3'd7 && cur_bit == pin_lvl_i |=> $stable(pin_state_o));

  // R4
  ext_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_vld_i && pin_idx_i == 3'd0 |=> ext_irq_o == $past(pin_lvl_i));

  // R6
  mck_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mck_set_ev |=> mck_req_o);

  // R7
  mck_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mck_ack_i && !mck_set_ev |=> !mck_req_o);

  // R8
  halt_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_vld_i && pin_idx_i == 3'd3 |=> halt_o == $past(pin_lvl_i));

  // R9
  hrst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hrst_o |=> !hrst_o);

  // R12
  bad_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_vld_i && pin_idx_i == 3'd7 |=> $stable(pin_state_o) && !hrst_o);
endmodule

bind irq_pin_conditioner irq_pin_conditioner_chk #(
  .NUM_PINS(NUM_PINS), .IDX_W(IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pin_vld_i   (pin_vld_i),
  .pin_idx_i   (pin_idx_i),
  .pin_lvl_i   (pin_lvl_i),
  .mck_ack_i   (mck_ack_i),
  .ext_irq_o   (ext_irq_o),
  .mck_req_o   (mck_req_o),
  .halt_o      (halt_o),
  .hrst_o      (hrst_o),
  .pin_state_o (pin_state_o)
);

// File: tb/irq_pin_conditioner_tb.sv
module irq_pin_conditioner_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin_vld_i = 1'b0;
  logic [2:0] pin_idx_i = '0;
  logic       pin_lvl_i = 1'b0;
  logic       mck_ack_i = 1'b0;
  logic       ext_irq_o, therm_irq_o, mck_req_o, srst_req_o, halt_o, hrst_o;
  logic [6:0] pin_state_o;

  always #2 clk = ~clk;

  irq_pin_conditioner u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_vld_i(pin_vld_i), .pin_idx_i(pin_idx_i),
    .pin_lvl_i(pin_lvl_i), .mck_ack_i(mck_ack_i), .ext_irq_o(ext_irq_o),
    .therm_irq_o(therm_irq_o), .mck_req_o(mck_req_o), .srst_req_o(srst_req_o),
    .halt_o(halt_o), .hrst_o(hrst_o), .pin_state_o(pin_state_o)
  );

  typedef struct {
    logic [12:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  // bench model
  logic [6:0] m_st = '0;
  logic m_ext = 0, m_th = 0, m_mck = 0, m_sr = 0, m_halt = 0, m_hr = 0;

  function automatic logic [12:0] actual();
    return {ext_irq_o, therm_irq_o, mck_req_o, srst_req_o, halt_o, hrst_o, pin_state_o};
  endfunction

  task automatic step(input int idx, input bit lvl, input bit v, input bit ack, input string tag);
    item_t it;
    bit    mset;
    @(negedge clk);
    pin_vld_i = v; pin_idx_i = 3'(idx); pin_lvl_i = lvl; mck_ack_i = ack;
    m_hr = 0; mset = 0;
    if (v && idx < 7 && m_st[idx] != lvl) begin
      case (idx)
        0: m_ext = lvl;
        1: m_th = lvl;
        2: if (!lvl) mset = 1;
        3: m_halt = lvl;
        4: if (lvl) m_hr = 1;
        5: m_sr = lvl;
        default: ;
      endcase
      m_st[idx] = lvl;
    end
    if (mset) m_mck = 1;
    else if (ack) m_mck = 0;
    it.exp = {m_ext, m_th, m_mck, m_sr, m_halt, m_hr, m_st};
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (actual() !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %b expected %b", it.tag, actual(), it.exp);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (actual() !== 13'd0) begin
      n_fail++;
      $display("FAIL R1 reset: actual %b expected %b", actual(), 13'd0);
    end
    rst_ni = 1'b1;

    step(0, 1, 1, 0, "R4 R3 ext rise");
    step(0, 1, 1, 0, "R2 ext repeat");
    step(0, 0, 1, 0, "R4 ext fall");
    step(1, 1, 1, 0, "R5 therm rise");
    step(1, 0, 1, 0, "R5 therm fall");
    step(2, 1, 1, 0, "R6 mck rise no set");
    step(2, 0, 1, 0, "R6 mck fall sets");
    step(0, 0, 0, 0, "R7 mck sticky idle");
    step(0, 0, 0, 1, "R7 mck ack clears");
    step(2, 1, 1, 0, "R6 mck rise again");
    step(2, 0, 1, 1, "R7 set beats ack");
    step(2, 0, 1, 1, "R2 mck repeat with ack");
    step(3, 1, 1, 0, "R8 checkstop halt");
    step(3, 1, 1, 0, "R2 checkstop repeat");
    step(3, 0, 1, 0, "R8 checkstop restart");
    step(4, 1, 1, 0, "R9 hreset pulse");
    step(0, 0, 0, 0, "R9 pulse ends");
    step(4, 1, 1, 0, "R2 hreset repeat no pulse");
    step(4, 0, 1, 0, "R9 hreset fall no pulse");
    step(4, 1, 1, 0, "R9 hreset pulse again");
    step(5, 1, 1, 0, "R10 soft reset on");
    step(5, 0, 1, 0, "R10 soft reset off");
    step(6, 1, 1, 0, "R11 tben state only");
    step(6, 0, 1, 0, "R11 tben clear");
    step(7, 1, 1, 0, "R12 bad index high");
    step(7, 0, 1, 0, "R12 bad index low");
    step(0, 1, 0, 0, "R2 no valid");
    step(0, 0, 0, 0, "R3 idle final");
    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule